// File: doc/BRIEF.md
# Open-Drain Data Line Direction Arbiter

This block joins a host-side data line to a card-side data line. Both lines idle high through passive pull-ups and are driven only low. Each clock the block samples both lines through two-flop synchronizers. The first side to pull its line low becomes the master. After a programmable delay, the block drives the opposite line low so that the zero is copied across. When the master lets its line go high again, the block stops pulling the slave line low. It then drives the slave line high for a short, programmable pulse so that the rising edge is fast. After that pulse, both lines fall back to passive pull-up.

A parameter sets how many identical lanes the block contains. By default there are three: the main data line and two auxiliary lines. The outputs are drive enables toward the pads, one pull-down and one pull-up per side per lane. Level shifting and current limiting are left to the pads. While the interface is disabled, every card-side line is held low and the host side is left floating high. Disabling also aborts any transfer in progress.

Top module: `odl_arbiter`

## Requirements
- R1: After reset, with `enable_i` high and both lines high on every lane, all four drive-enable outputs of every lane are 0.
- R2: A host line that falls while its lane is idle sets `card_pd_o` of that lane to 1 on the DLY_CYC+3rd rising clock edge after the fall. The three extra edges are two for synchronization and one for detection. `host_pd_o` stays 0 throughout.
- R3: A card line that falls while its lane is idle sets `host_pd_o` of that lane after the same DLY_CYC+3 edges. `card_pd_o` stays 0 throughout.
- R4: If both lines of a lane fall in the same cycle, the host side wins. Only `card_pd_o` is asserted.
- R5: Once a master is chosen, a fall on the slave line is ignored. It neither delays nor cancels the copy, and it never asserts the master side's pull-down.
- R6: When the master line returns high, the slave pull-down is released and the slave pull-up is asserted in the same cycle. This happens on the 3rd rising edge after the release. The pull-up stays high for exactly PU_CYC cycles, after which all four outputs of the lane are 0.
- R7: No lane ever enables pull-down and pull-up on the same side at once, and no lane ever pulls both sides low.
- R8: While `enable_i` is 0, every `card_pd_o` bit is 1 and all other outputs are 0. Any transfer in progress is dropped, so no pull-up pulse follows re-enabling. A line fall that happens while disabled starts no transfer.
- R9: Lanes are independent. A transfer on one lane leaves all outputs of the other lanes at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Interface active; 0 holds card lines low |
| host_i | input | NUM_LINES | Sensed level of each host-side line |
| card_i | input | NUM_LINES | Sensed level of each card-side line |
| host_pd_o | output | NUM_LINES | Pull host line low |
| host_pu_o | output | NUM_LINES | Actively drive host line high |
| card_pd_o | output | NUM_LINES | Pull card line low |
| card_pu_o | output | NUM_LINES | Actively drive card line high |

## Verification
The bench builds the block with NUM_LINES=3, DLY_CYC=3 and PU_CYC=2. These values keep the delay and pulse windows short, which makes a full sweep practical. The sweep covers every lane, both master sides and four hold lengths, and it times each edge exactly against DLY_CYC+3 and PU_CYC. The small delay also leaves room to inject a slave-side fall after a master is chosen but before the copy appears. The lines are modelled as wired-AND of the external driver and the block's pull-down, so each copied zero shows up on the opposite line just as a pad would produce it.

// File: rtl/odl_pkg.sv
package odl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_HOLD  = 2'd2,
    ST_PULSE = 2'd3
  } lane_state_e;

  typedef enum logic {
    SIDE_HOST = 1'b0,
    SIDE_CARD = 1'b1
  } side_e;
endpackage

// File: rtl/odl_sync.sv
module odl_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/odl_lane.sv
module odl_lane
  import odl_pkg::*;
#(
  parameter int DLY_CYC = 40,
  parameter int PU_CYC  = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic host_i,
  input  logic card_i,
  output logic host_pd_o,
  output logic host_pu_o,
  output logic card_pd_o,
  output logic card_pu_o
);
  localparam int MAX_CYC = (DLY_CYC > PU_CYC) ? DLY_CYC : PU_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DLY_CYC - 1);
  localparam logic [CNT_W-1:0] PU_LAST  = CNT_W'(PU_CYC - 1);

  logic host_s, card_s, host_q, card_q;
  logic host_fall, card_fall, mst_high;
  lane_state_e state_q;
  side_e       mst_q;
  logic [CNT_W-1:0] cnt_q;

  odl_sync #(.RST_VAL(1'b1)) u_sync_host (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(host_i), .q_o(host_s)
  );
  odl_sync #(.RST_VAL(1'b1)) u_sync_card (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(card_i), .q_o(card_s)
  );

  assign host_fall = host_q & ~host_s;
  assign card_fall = card_q & ~card_s;
  assign mst_high  = (mst_q == SIDE_HOST) ? host_s : card_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mst_q   <= SIDE_HOST;
      cnt_q   <= '0;
      host_q  <= 1'b1;
      card_q  <= 1'b1;
    end else begin
      host_q <= host_s;
      card_q <= card_s;
      if (!en_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            cnt_q <= '0;
            // host side wins a same-cycle tie
            if (host_fall) begin
              mst_q   <= SIDE_HOST;
              state_q <= ST_DELAY;
            end else if (card_fall) begin
              mst_q   <= SIDE_CARD;
              state_q <= ST_DELAY;
            end
          end
          ST_DELAY: begin
            if (cnt_q == DLY_LAST) begin
              cnt_q   <= '0;
              state_q <= ST_HOLD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_HOLD: begin
            if (mst_high) begin
              cnt_q   <= '0;
              state_q <= ST_PULSE;
            end
          end
          ST_PULSE: begin
            if (cnt_q == PU_LAST) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  logic slave_pd, slave_pu, mst_host;
  assign slave_pd = (state_q == ST_HOLD);
  assign slave_pu = (state_q == ST_PULSE);
  assign mst_host = (mst_q == SIDE_HOST);

  assign card_pd_o = ~en_i | (slave_pd & mst_host);
  assign card_pu_o = en_i & slave_pu & mst_host;
  assign host_pd_o = en_i & slave_pd & ~mst_host;
  assign host_pu_o = en_i & slave_pu & ~mst_host;
endmodule

// File: rtl/odl_arbiter.sv
module odl_arbiter #(
  parameter int NUM_LINES = 3,
  parameter int DLY_CYC   = 40,
  parameter int PU_CYC    = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enable_i,
  input  logic [NUM_LINES-1:0] host_i,
  input  logic [NUM_LINES-1:0] card_i,
  output logic [NUM_LINES-1:0] host_pd_o,
  output logic [NUM_LINES-1:0] host_pu_o,
  output logic [NUM_LINES-1:0] card_pd_o,
  output logic [NUM_LINES-1:0] card_pu_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
    odl_lane #(
      .DLY_CYC(DLY_CYC),
      .PU_CYC (PU_CYC)
    ) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (enable_i),
      .host_i   (host_i[g]),
      .card_i   (card_i[g]),
      .host_pd_o(host_pd_o[g]),
      .host_pu_o(host_pu_o[g]),
      .card_pd_o(card_pd_o[g]),
      .card_pu_o(card_pu_o[g])
    );
  end
endmodule

// File: rtl/odl_arbiter_chk.sv
module odl_arbiter_chk #(
  parameter int NUM_LINES = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 enable_i,
  input logic [NUM_LINES-1:0] host_pd_o,
  input logic [NUM_LINES-1:0] host_pu_o,
  input logic [NUM_LINES-1:0] card_pd_o,
  input logic [NUM_LINES-1:0] card_pu_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    p_side_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(host_pd_o[g] && host_pu_o[g]) && !(card_pd_o[g] && card_pu_o[g]));

    p_one_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(host_pd_o[g] && card_pd_o[g]));

    p_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |-> (card_pd_o[g] && !host_pd_o[g] && !host_pu_o[g] && !card_pu_o[g]));

    p_card_pulse_after_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && $rose(card_pu_o[g])) |-> $past(card_pd_o[g]));

    p_host_pulse_after_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && $rose(host_pu_o[g])) |-> $past(host_pd_o[g]));

    p_card_hold_ends_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && $past(enable_i) && $fell(card_pd_o[g])) |-> card_pu_o[g]);

    p_host_hold_ends_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && $past(enable_i) && $fell(host_pd_o[g])) |-> host_pu_o[g]);
  end
endmodule

bind odl_arbiter odl_arbiter_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .host_pd_o(host_pd_o),
  .host_pu_o(host_pu_o),
  .card_pd_o(card_pd_o),
  .card_pu_o(card_pu_o)
);

// File: tb/odl_arbiter_tb_top.sv
`timescale 1ns/100ps
module odl_arbiter_tb_top;
  localparam int N   = 3;
  localparam int DLY = 3;
  localparam int PU  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic [N-1:0] host_drv = '0;
  logic [N-1:0] card_drv = '0;
  logic [N-1:0] host_line, card_line;
  logic [N-1:0] host_pd, host_pu, card_pd, card_pu;
  int n_vec = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign host_line = ~(host_drv | host_pd);
  assign card_line = ~(card_drv | card_pd);

  odl_arbiter #(.NUM_LINES(N), .DLY_CYC(DLY), .PU_CYC(PU)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable),
    .host_i(host_line), .card_i(card_line),
    .host_pd_o(host_pd), .host_pu_o(host_pu),
    .card_pd_o(card_pd), .card_pu_o(card_pu)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs_of(input int ln);
    return {28'd0, host_pd[ln], host_pu[ln], card_pd[ln], card_pu[ln]};
  endfunction

  function automatic int others(input int ln);
    int acc = 0;
    for (int k = 0; k < N; k++) if (k != ln) acc |= outs_of(k);
    return acc;
  endfunction

  function automatic bit spd(input int ln, input bit card_mst);
    return card_mst ? host_pd[ln] : card_pd[ln];
  endfunction
  function automatic bit spu(input int ln, input bit card_mst);
    return card_mst ? host_pu[ln] : card_pu[ln];
  endfunction
  function automatic bit mpd(input int ln, input bit card_mst);
    return card_mst ? card_pd[ln] : host_pd[ln];
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_slave_pd(input int ln, input bit cm, output int lat, output bit mst_hit);
    lat = 0;
    mst_hit = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      lat++;
      if (mpd(ln, cm)) mst_hit = 1;
      if (spd(ln, cm)) break;
    end
  endtask

  task automatic finish_release(input int ln, input bit cm);
    int lat, cnt;
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      step();
      lat++;
      if (spu(ln, cm)) break;
    end
    chk(lat == 3, "R6 release-to-pulse", lat, 3);
    chk(!spd(ln, cm), "R6 pull-down dropped", int'(spd(ln, cm)), 0);
    cnt = 0;
    while (spu(ln, cm) && cnt < 20) begin
      cnt++;
      step();
    end
    chk(cnt == PU, "R6 pulse width", cnt, PU);
    chk(outs_of(ln) == 0, "R6 idle after pulse", outs_of(ln), 0);
  endtask

  task automatic transact(input int ln, input bit cm, input int hold);
    int lat;
    bit mh;
    if (cm) card_drv[ln] = 1'b1; else host_drv[ln] = 1'b1;
    wait_slave_pd(ln, cm, lat, mh);
    chk(lat == DLY + 3, cm ? "R3 copy latency" : "R2 copy latency", lat, DLY + 3);
    chk(!mh, cm ? "R3 master side untouched" : "R2 master side untouched", int'(mh), 0);
    chk(others(ln) == 0, "R9 other lanes quiet", others(ln), 0);
    for (int k = 0; k < hold; k++) step();
    chk(spd(ln, cm) && !mpd(ln, cm), cm ? "R3 hold" : "R2 hold", outs_of(ln), cm ? 8 : 2);
    if (cm) card_drv[ln] = 1'b0; else host_drv[ln] = 1'b0;
    finish_release(ln, cm);
    chk(others(ln) == 0, "R9 other lanes quiet after", others(ln), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    int lat;
    bit mh;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    // R1
    for (int ln = 0; ln < N; ln++)
      chk(outs_of(ln) == 0, "R1 idle after reset", outs_of(ln), 0);

    // R2 R3 R6 R9 sweep
    for (int ln = 0; ln < N; ln++)
      for (int m = 0; m < 2; m++)
        for (int h = 0; h < 4; h++) begin
          transact(ln, bit'(m), h);
          repeat (3) step();
        end

    // R4: simultaneous fall on lane 1
    host_drv[1] = 1'b1;
    card_drv[1] = 1'b1;
    wait_slave_pd(1, 1'b0, lat, mh);
    chk(lat == DLY + 3 && !mh, "R4 host wins tie", lat, DLY + 3);
    repeat (3) step();
    chk(host_pd[1] == 1'b0, "R4 host side never pulled", int'(host_pd[1]), 0);
    card_drv[1] = 1'b0;
    repeat (2) step();
    host_drv[1] = 1'b0;
    finish_release(1, 1'b0);
    repeat (3) step();

    // R5: card falls after host became master but before copy
    host_drv[2] = 1'b1;
    repeat (4) step();
    card_drv[2] = 1'b1;
    seen = 0;
    lat = 4;
    for (int k = 0; k < 30; k++) begin
      step();
      lat++;
      if (host_pd[2]) seen = 1;
      if (card_pd[2]) break;
    end
    chk(lat == DLY + 3, "R5 copy not delayed", lat, DLY + 3);
    chk(!seen, "R5 slave fall ignored", int'(seen), 0);
    card_drv[2] = 1'b0;
    repeat (3) step();
    chk(card_pd[2] && !host_pd[2], "R5 still master host", outs_of(2), 2);
    host_drv[2] = 1'b0;
    finish_release(2, 1'b0);
    repeat (3) step();

    // R8: abort mid-transfer
    host_drv[0] = 1'b1;
    wait_slave_pd(0, 1'b0, lat, mh);
    enable = 1'b0;
    #0.1;
    chk(card_pd == '1 && host_pd == 0 && host_pu == 0 && card_pu == 0,
        "R8 disabled outputs", {host_pd, card_pd}, 7);
    step();
    host_drv[0] = 1'b0;
    repeat (4) step();
    chk(card_pd == '1 && host_pu == 0 && card_pu == 0, "R8 disabled hold", int'(card_pd), 7);
    host_drv[1] = 1'b1;
    repeat (4) step();
    enable = 1'b1;
    seen = 0;
    for (int k = 0; k < DLY + PU + 8; k++) begin
      step();
      for (int ln = 0; ln < N; ln++) if (outs_of(ln) != 0) seen = 1;
    end
    chk(!seen, "R8 no pulse or transfer after re-enable", int'(seen), 0);
    host_drv[1] = 1'b0;
    repeat (4) step();
    for (int ln = 0; ln < N; ln++)
      chk(outs_of(ln) == 0, "R8 idle after re-enable", outs_of(ln), 0);

    // R7 spot check after re-enable: fresh transfer works
    transact(0, 1'b1, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule